// File: doc/BRIEF.md
# Receive Port Output Formatter

This block sits between a demodulator and an external link controller. It presents the demodulated header and payload bits on a serial data line, together with a gated bit clock and an active-high framing strobe that covers the whole transfer. The demodulator supplies a start-frame-delimiter pulse, a bit stream with a bit-valid strobe, an external header-error flag and a flag that marks the bits of the header's 16-bit check field. Delimiter search, despreading and demodulation happen upstream.

The formatter checks the header itself with a CRC-16 (polynomial x^16+x^12+x^5+1, register preset to all ones). A mismatch ends the frame at the close of the check field. The bit clock idles until a delimiter arrives and stays low through the check field. Each clock pulse is high for half a bit period. The half period is given in master clocks by an input, so the upstream rate selection sets it. A configuration input inverts the clock's polarity. Removing the receive enable puts the port in standby.

Top module: `rx_port_fmt`

## Requirements
- R1: After reset the strobe is 0, the data line is 0 and the bit clock sits at its idle level (0, or 1 when `clk_inv` is 1).
- R2: The strobe rises on the cycle after a delimiter pulse seen with `rx_en` high. A delimiter pulse while `rx_en` is low is ignored.
- R3: While `rx_en` is low the port is in standby. The strobe is 0 from the cycle after `rx_en` is sampled low.
- R4: An active `hdr_err` while the strobe is high drops the strobe on the next cycle.
- R5: The CRC runs over the header bits, which are the accepted bits before the check field. The check field is the 16 accepted bits with `crc_flag` high. It carries the ones' complement of the CRC register, most significant bit first. If the field does not match, the strobe drops on the cycle after its 16th bit. If it matches, the frame goes on to the payload, and `crc_flag` is ignored from then on.
- R6: A bit is accepted at a clock edge when the strobe, `bit_vld` and `rx_en` are high and `hdr_err` and `sfd_det` are low. It appears on `rx_data` one cycle later and holds until the next accepted bit. Bits keep their arrival order (octets arrive least significant bit first).
- R7: For an accepted non-field bit at edge t, with h = `half_len` (h ≥ 1), the internal bit clock is high after edges t+h through t+2h-1. Its rising edge falls in the middle of the data bit.
- R8: The bit clock gives no pulse for check-field bits. A pulse that is still running is cut off when a field bit is accepted.
- R9: While the strobe is low, `rx_data` does not change and the bit clock stays at its idle level. After a drop, all bits are ignored until the next delimiter.
- R10: `clk_inv` = 1 inverts `rx_bitclk` at all times, idle level included.
- R11: A delimiter pulse during an active frame restarts header collection and the CRC. The strobe stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; low means standby |
| sfd_det | input | 1 | One-cycle delimiter-detect pulse |
| bit_vld | input | 1 | Demodulated bit valid |
| bit_in | input | 1 | Demodulated bit |
| hdr_err | input | 1 | External header-error flag |
| crc_flag | input | 1 | Marks bits of the header check field |
| half_len | input | HALF_W | Master clocks per half bit period (≥ 1) |
| clk_inv | input | 1 | Inverts the output bit clock |
| rx_data | output | 1 | Serial data to the controller |
| rx_bitclk | output | 1 | Gated bit clock |
| rx_frame | output | 1 | Framing strobe, active high |

## Verification
Timing is counted from the rising edge at which the bench's inputs are sampled:
- The strobe and the data line are due one edge after that.
- A bit clock pulse is due from h edges after the accepting edge until 2h-1 edges after it.

The bench drives inputs on the falling edge and updates a behavioural model right after every rising edge. It compares all three outputs at the next falling edge, so each result is checked in exactly the cycle it is due. Clock-spacing cases use h of 1, 2 and 3, with bit gaps both equal to and longer than one bit period.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HDR  = 2'd1,
      PH_PAY  = 2'd2
   } rxf_phase_e;

   localparam logic [15:0] RXF_CCITT_POLY = 16'h1021;
endpackage

// File: rtl/rxf_crc.sv
module rxf_crc #(
   parameter int W = 16,
   parameter logic [W-1:0] POLY = W'(16'h1021)
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] crc
);
   logic         fb;
   logic [W-1:0] crc_nxt;

   always_comb begin
      fb      = crc[W-1] ^ din;
      crc_nxt = {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc <= '1;
      else if (init) crc <= '1;
      else if (en)   crc <= crc_nxt;
   end
endmodule

// File: rtl/rxf_frame_ctl.sv
module rxf_frame_ctl
   import rxf_pkg::*;
#(
   parameter int W = 16
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_en,
   input  logic         sfd_det,
   input  logic         bit_vld,
   input  logic         bit_in,
   input  logic         hdr_err,
   input  logic         crc_flag,
   input  logic [W-1:0] crc_calc,
   output logic         strobe,
   output logic         accept,
   output logic         hdr_upd,
   output logic         crc_init,
   output logic         clk_start,
   output logic         clk_stop
);
   localparam int CW = $clog2(W + 1);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   rxf_phase_e   ph_q;
   logic [CW-1:0] fcnt_q;
   logic [W-1:0]  fld_q, fld_nxt;
   logic          in_fld, fld_last, crc_bad, drop;

   always_comb begin
      accept    = strobe & bit_vld & rx_en & ~hdr_err & ~sfd_det;
      in_fld    = accept & (ph_q == PH_HDR) & crc_flag;
      hdr_upd   = accept & (ph_q == PH_HDR) & ~crc_flag;
      fld_nxt   = {fld_q[W-2:0], bit_in};
      fld_last  = in_fld & (fcnt_q == LAST);
      crc_bad   = fld_last & (fld_nxt != ~crc_calc);
      drop      = ~rx_en | (strobe & hdr_err & ~sfd_det) | crc_bad;
      crc_init  = rx_en & sfd_det;
      clk_start = accept & ~in_fld;
      clk_stop  = drop | sfd_det | in_fld;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe <= 1'b0;
         ph_q   <= PH_IDLE;
         fcnt_q <= '0;
         fld_q  <= '0;
      end else if (!rx_en) begin
         strobe <= 1'b0;
         ph_q   <= PH_IDLE;
      end else if (sfd_det) begin
         strobe <= 1'b1;
         ph_q   <= PH_HDR;
         fcnt_q <= '0;
         fld_q  <= '0;
      end else if (strobe && hdr_err) begin
         strobe <= 1'b0;
         ph_q   <= PH_IDLE;
      end else if (in_fld) begin
         fld_q  <= fld_nxt;
         fcnt_q <= fcnt_q + 1'b1;
         if (fld_last) begin
            if (crc_bad) begin
               strobe <= 1'b0;
               ph_q   <= PH_IDLE;
            end else begin
               ph_q   <= PH_PAY;
            end
         end
      end
   end

   // R2
   strobe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && !(rx_en && sfd_det)) |=> !strobe);
   // R3
   standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (!strobe && ph_q == PH_IDLE));
   // R4
   hdr_err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && rx_en && hdr_err && !sfd_det) |=> !strobe);
   // R5
   crc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fld_last && !crc_bad && rx_en) |=> (strobe && ph_q == PH_PAY));
   // R11
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && sfd_det) |=> (strobe && ph_q == PH_HDR && fcnt_q == '0));
endmodule

// File: rtl/rxf_bitclk.sv
module rxf_bitclk #(
   parameter int HALF_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HALF_W-1:0] half_len,
   input  logic              start,
   input  logic              stop,
   output logic              clk_raw
);
   localparam int CW = HALF_W + 1;

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (stop)           cnt_q <= '0;
      else if (start)          cnt_q <= {half_len, 1'b0};
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign clk_raw = (cnt_q != '0) && (cnt_q <= {1'b0, half_len});

   // R7
   half_len_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (half_len != '0));
   // R8
   stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !clk_raw);
endmodule

// File: rtl/rx_port_fmt.sv
module rx_port_fmt #(
   parameter int HALF_W = 8,
   parameter int CRC_W  = 16,
   parameter logic [CRC_W-1:0] CRC_POLY = CRC_W'(rxf_pkg::RXF_CCITT_POLY),
   parameter bit POL_CFG = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              sfd_det,
   input  logic              bit_vld,
   input  logic              bit_in,
   input  logic              hdr_err,
   input  logic              crc_flag,
   input  logic [HALF_W-1:0] half_len,
   input  logic              clk_inv,
   output logic              rx_data,
   output logic              rx_bitclk,
   output logic              rx_frame
);
   generate
      if (HALF_W < 1 || HALF_W > 24) begin : g_bad_half
         $error("rx_port_fmt: HALF_W out of range");
      end
      if (CRC_W < 8 || CRC_W > 32) begin : g_bad_crc
         $error("rx_port_fmt: CRC_W out of range");
      end
   endgenerate

   logic             accept, hdr_upd, crc_init, clk_start, clk_stop, clk_raw;
   logic [CRC_W-1:0] crc_val;

   rxf_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .clk(clk), .rst_n(rst_n), .init(crc_init), .en(hdr_upd),
      .din(bit_in), .crc(crc_val)
   );

   rxf_frame_ctl #(.W(CRC_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sfd_det(sfd_det),
      .bit_vld(bit_vld), .bit_in(bit_in), .hdr_err(hdr_err),
      .crc_flag(crc_flag), .crc_calc(crc_val), .strobe(rx_frame),
      .accept(accept), .hdr_upd(hdr_upd), .crc_init(crc_init),
      .clk_start(clk_start), .clk_stop(clk_stop)
   );

   rxf_bitclk #(.HALF_W(HALF_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .half_len(half_len),
      .start(clk_start), .stop(clk_stop), .clk_raw(clk_raw)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rx_data <= 1'b0;
      else if (accept) rx_data <= bit_in;
   end

   generate
      if (POL_CFG) begin : g_pol_prog
         assign rx_bitclk = clk_raw ^ clk_inv;
      end else begin : g_pol_fixed
         assign rx_bitclk = clk_raw;
      end
   endgenerate

   // R9
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(rx_data));
   // R9
   clk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_raw |-> rx_frame);
endmodule

// File: tb/tb_rx_port_fmt.sv
`timescale 1ns/1ps
module tb_rx_port_fmt;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_en = 1'b0, sfd_det = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
   logic hdr_err = 1'b0, crc_flag = 1'b0, clk_inv = 1'b0;
   logic [7:0] half_len = 8'd2;
   logic rx_data, rx_bitclk, rx_frame;

   int checks = 0, failures = 0;
   bit done = 0;
   int unsigned seed = 32'h1234_5678;

   // reference model state
   bit m_strb, m_data, m_inhdr, m_pulse;
   int cyc, t_acc, m_fldn, m_fldv;
   bit m_hdrq[$];

   always #2.5 clk = ~clk;

   rx_port_fmt #(.HALF_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sfd_det(sfd_det),
      .bit_vld(bit_vld), .bit_in(bit_in), .hdr_err(hdr_err),
      .crc_flag(crc_flag), .half_len(half_len), .clk_inv(clk_inv),
      .rx_data(rx_data), .rx_bitclk(rx_bitclk), .rx_frame(rx_frame)
   );

   function automatic int crc_of(bit q[$]);
      int r = 'hFFFF;
      foreach (q[i]) begin
         bit fb = bit'((r >> 15) & 1) ^ q[i];
         r = (r << 1) & 'hFFFF;
         if (fb) r = r ^ 'h1021;
      end
      return r;
   endfunction

   function automatic bit rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed[16];
   endfunction

   task automatic check(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d t=%0t", what, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      bit acc;
      cyc++;
      if (!rst_n) begin
         m_strb = 0; m_data = 0; m_inhdr = 0; m_pulse = 0;
         m_fldn = 0; m_fldv = 0; m_hdrq.delete();
         return;
      end
      acc = m_strb && bit_vld && rx_en && !hdr_err && !sfd_det;
      if (acc) m_data = bit_in;
      if (!rx_en) begin
         m_strb = 0; m_pulse = 0;
      end else if (sfd_det) begin
         m_strb = 1; m_inhdr = 1; m_pulse = 0;
         m_fldn = 0; m_fldv = 0; m_hdrq.delete();
      end else if (m_strb && hdr_err) begin
         m_strb = 0; m_pulse = 0;
      end else if (acc) begin
         if (m_inhdr && crc_flag) begin
            m_pulse = 0;
            m_fldv = ((m_fldv << 1) | int'(bit_in)) & 'hFFFF;
            m_fldn++;
            if (m_fldn == 16) begin
               if (m_fldv != ((~crc_of(m_hdrq)) & 'hFFFF)) m_strb = 0;
               else m_inhdr = 0;
            end
         end else begin
            if (m_inhdr) m_hdrq.push_back(bit_in);
            m_pulse = 1;
            t_acc = cyc;
         end
      end
   endtask

   task automatic tick();
      int d, h;
      bit raw;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      h = int'(half_len);
      d = cyc - t_acc;
      raw = m_pulse && d >= h && d <= 2*h - 1;
      check("R2 R3 R4 R5 R11 frame strobe", int'(rx_frame), int'(m_strb));
      check("R6 R9 serial data", int'(rx_data), int'(m_data));
      check("R7 R8 R10 bit clock", int'(rx_bitclk), int'(raw ^ clk_inv));
   endtask

   task automatic send_bit(bit b, bit cf, int gap);
      bit_vld = 1; bit_in = b; crc_flag = cf;
      tick();
      bit_vld = 0; crc_flag = 0;
      for (int i = 1; i < gap; i++) tick();
   endtask

   task automatic frame(int nh, bit bad, int np, int gap, bit cf_pay);
      bit hq[$];
      int c;
      sfd_det = 1; tick(); sfd_det = 0;
      for (int i = 0; i < nh; i++) begin
         bit b = rnd();
         hq.push_back(b);
         send_bit(b, 1'b0, gap);
      end
      c = (~crc_of(hq)) & 'hFFFF;
      if (bad) c = c ^ 'h0100;
      for (int i = 15; i >= 0; i--) send_bit(c[i], 1'b1, gap);
      for (int i = 0; i < np; i++) send_bit(rnd(), cf_pay & i[0], gap);
   endtask

   initial begin
      cyc = 0; t_acc = -100;
      repeat (3) tick();
      // R1: reset state
      check("R1 reset strobe", int'(rx_frame), 0);
      check("R1 reset data", int'(rx_data), 0);
      check("R1 reset clock idle", int'(rx_bitclk), int'(clk_inv));
      rst_n = 1; tick();

      // R2: delimiter with rx_en low ignored; R9 bits ignored
      sfd_det = 1; tick(); sfd_det = 0;
      rx_en = 1; tick();
      check("R2 no frame on disabled delimiter", int'(rx_frame), 0);
      for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0, 4);

      // R5 R6 R7 R8: good frame, h=2, payload flag ignored
      frame(24, 1'b0, 16, 4, 1'b1);
      check("R5 frame alive after good check field", int'(rx_frame), 1);
      // R3: standby
      rx_en = 0; tick(); rx_en = 1;
      check("R3 strobe dropped in standby", int'(rx_frame), 0);
      for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0, 4);

      // R5: corrupted check field, R9 later bits ignored
      frame(16, 1'b1, 0, 4, 1'b0);
      check("R5 strobe dropped on bad check field", int'(rx_frame), 0);
      for (int i = 0; i < 6; i++) send_bit(rnd(), 1'b0, 4);

      // R4: header error mid header
      sfd_det = 1; tick(); sfd_det = 0;
      for (int i = 0; i < 5; i++) send_bit(rnd(), 1'b0, 4);
      hdr_err = 1; tick(); hdr_err = 0;
      check("R4 strobe dropped on header error", int'(rx_frame), 0);
      for (int i = 0; i < 4; i++) send_bit(rnd(), 1'b0, 4);

      // R10: inverted clock, h=1
      clk_inv = 1; half_len = 8'd1; tick();
      check("R10 idle level inverted", int'(rx_bitclk), 1);
      frame(20, 1'b0, 10, 2, 1'b0);
      rx_en = 0; tick(); rx_en = 1;

      // R7: h=3 with bit gap longer than one period
      clk_inv = 0; half_len = 8'd3; tick();
      frame(18, 1'b0, 8, 9, 1'b0);

      // R11: restart mid payload, new frame must pass its own check
      frame(12, 1'b0, 0, 6, 1'b0);
      check("R11 strobe kept through restart", int'(rx_frame), 1);
      rx_en = 0; tick(); tick();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired act=0 exp=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule